// File: doc/BRIEF.md
# Variable-Length Instruction Fetcher

This block reads instructions of one, two or three bytes from a memory that is eight bits wide. It makes one read per byte, so a long instruction costs more memory cycles than a short one. The first byte is the opcode, and its two top bits say how many bytes follow. The opcode goes to its own register. Any bytes after it are gathered, low byte first, into a 16-bit operand register.

A fetch begins when a start strobe is seen while the unit is idle. The internal program counter advances once for every byte read and then stays put until the next fetch, so back-to-back fetches walk through the program in order. When the last byte has been taken in, the unit raises a done pulse for one clock. At that point the results are valid and stay valid until the next opcode is captured:

- the opcode and the operand,
- the decoded length,
- the address of the next instruction,
- a return address, as a call would need it,
- a relative-jump target, formed from the first byte's address plus the sign-extended low operand byte.

Top module: `varlen_fetch`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done` and `mem_rd` are 0 and `next_pc` equals the parameter `RESET_ADDR`.
- R2: The length is decoded from opcode bits [7:6]: 00 gives 1 byte, 01 gives 2 bytes, 10 gives 3 bytes, and 11 is treated as 1 byte. `ins_len` shows this count (1, 2 or 3) while `done` is high.
- R3: A fetch asserts `mem_rd` for exactly as many consecutive cycles as the instruction has bytes. `mem_addr` starts at the first-byte address and rises by one in each read cycle. Data is taken from `mem_rdata` at the clock edge that ends each read cycle.
- R4: `opcode` holds the first byte. For a 2-byte instruction `operand` is {8'h00, byte2}. For a 3-byte instruction it is {byte3, byte2}. For a 1-byte instruction it is 0.
- R5: If `start_i` is sampled at clock edge k in idle, `done` is high for exactly one cycle: the cycle that follows edge k+len.
- R6: While `done` is high, `next_pc` equals the first-byte address plus the length, modulo 2^16. The next fetch starts from that address.
- R7: While `done` is high, `ret_addr` equals the address just past the last byte. A 3-byte instruction at 0x1234 gives 0x1237.
- R8: While `done` is high, `rel_target` equals the first-byte address plus the sign-extended `operand[7:0]`, modulo 2^16.
- R9: `start_i` is ignored during read cycles and during the done cycle. After `done`, no read happens until a new start is sampled in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to fetch one instruction |
| mem_rdata | input | 8 | Byte returned by memory for `mem_addr` |
| mem_addr | output | 16 | Byte address being read |
| mem_rd | output | 1 | Read cycle in progress |
| opcode | output | 8 | First byte of the fetched instruction |
| operand | output | 16 | Following bytes, low byte first |
| ins_len | output | 2 | Instruction length in bytes |
| done | output | 1 | One-cycle pulse when the instruction is complete |
| next_pc | output | 16 | Address of the following instruction |
| ret_addr | output | 16 | Return address for a call |
| rel_target | output | 16 | First-byte address plus signed displacement |

## Verification
The hardest case to produce is a start strobe that arrives while a fetch is already running, including during the done cycle. A flaw there only shows up as a stray extra read later on. To reach it, the stimulus holds `start_i` high across the whole of a one-byte fetch and across part of a three-byte fetch. It then watches the idle cycles that follow for unexpected reads. The program is laid out so that a three-byte instruction sits at 0x1234, and so that displacements of 0x80, 0xFE and 0x7F exercise both the sign-extension limits and the borrow into the upper address byte.

// File: rtl/vf_pkg.sv
package vf_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int LANES  = 2;
    localparam int OPND_W = LANES * DATA_W;
    localparam int LEN_W  = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [OPND_W-1:0] opnd_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPC,
        FS_LO,
        FS_HI,
        FS_DONE
    } fstate_e;

    typedef struct packed {
        byte_t opcode;
        opnd_t operand;
        len_t  len;
    } ifetch_t;

    // Length class lives in the two top opcode bits.
    function automatic len_t op_length(byte_t op);
        unique case (op[DATA_W-1 -: 2])
            2'b01:   return len_t'(2);
            2'b10:   return len_t'(3);
            default: return len_t'(1);
        endcase
    endfunction

    function automatic addr_t sext_disp(byte_t d);
        return {{(ADDR_W-DATA_W){d[DATA_W-1]}}, d};
    endfunction

    function automatic addr_t len_to_addr(len_t l);
        return {{(ADDR_W-LEN_W){1'b0}}, l};
    endfunction
endpackage

// File: rtl/vf_ctrl.sv
module vf_ctrl
    import vf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  len_t             op_len,
    input  len_t             held_len,
    output logic             rd,
    output logic             cap_op,
    output logic [LANES-1:0] cap_lane,
    output logic             done
);
    fstate_e st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            FS_IDLE: if (start_i) nxt = FS_OPC;
            FS_OPC:  nxt = (op_len == len_t'(1)) ? FS_DONE : FS_LO;
            FS_LO:   nxt = (held_len == len_t'(3)) ? FS_HI : FS_DONE;
            FS_HI:   nxt = FS_DONE;
            FS_DONE: nxt = FS_IDLE;
            default: nxt = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= FS_IDLE;
        else     st <= nxt;
    end

    assign rd          = (st == FS_OPC) || (st == FS_LO) || (st == FS_HI);
    assign cap_op      = (st == FS_OPC);
    assign cap_lane[0] = (st == FS_LO);
    assign cap_lane[1] = (st == FS_HI);
    assign done        = (st == FS_DONE);
endmodule

// File: rtl/vf_pc.sv
module vf_pc
    import vf_pkg::*;
#(
    parameter addr_t RESET_ADDR = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  mark,
    output addr_t pc,
    output addr_t first_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc         <= RESET_ADDR;
            first_addr <= RESET_ADDR;
        end else begin
            if (adv)  pc         <= pc + addr_t'(1);
            if (mark) first_addr <= pc;
        end
    end
endmodule

// File: rtl/vf_capture.sv
module vf_capture
    import vf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_op,
    input  logic [LANES-1:0] cap_lane,
    input  byte_t            rdata,
    output ifetch_t          word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word.opcode <= '0;
            word.len    <= len_t'(1);
        end else if (cap_op) begin
            word.opcode <= rdata;
            word.len    <= op_length(rdata);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || cap_op)    word.operand[g*DATA_W +: DATA_W] <= '0;
            else if (cap_lane[g]) word.operand[g*DATA_W +: DATA_W] <= rdata;
        end
    end
endmodule

// File: rtl/vf_target.sv
module vf_target
    import vf_pkg::*;
(
    input  addr_t first_addr,
    input  len_t  len,
    input  byte_t disp,
    output addr_t ret_addr,
    output addr_t rel_target
);
    assign ret_addr   = first_addr + len_to_addr(len);
    assign rel_target = first_addr + sext_disp(disp);
endmodule

// File: rtl/varlen_fetch.sv
module varlen_fetch
    import vf_pkg::*;
#(
    parameter addr_t RESET_ADDR = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic [7:0]  opcode,
    output logic [15:0] operand,
    output logic [1:0]  ins_len,
    output logic        done,
    output logic [15:0] next_pc,
    output logic [15:0] ret_addr,
    output logic [15:0] rel_target
);
    logic             cap_op;
    logic [LANES-1:0] cap_lane;
    addr_t            pc, first_addr;
    ifetch_t          word;

    vf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_len   (op_length(mem_rdata)),
        .held_len (word.len),
        .rd       (mem_rd),
        .cap_op   (cap_op),
        .cap_lane (cap_lane),
        .done     (done)
    );

    vf_pc #(.RESET_ADDR(RESET_ADDR)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .adv        (mem_rd),
        .mark       (cap_op),
        .pc         (pc),
        .first_addr (first_addr)
    );

    vf_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_op   (cap_op),
        .cap_lane (cap_lane),
        .rdata    (mem_rdata),
        .word     (word)
    );

    vf_target u_tgt (
        .first_addr (first_addr),
        .len        (word.len),
        .disp       (word.operand[DATA_W-1:0]),
        .ret_addr   (ret_addr),
        .rel_target (rel_target)
    );

    assign mem_addr = pc;
    assign next_pc  = pc;
    assign opcode   = word.opcode;
    assign operand  = word.operand;
    assign ins_len  = word.len;
endmodule

// File: rtl/vf_checker.sv
module vf_checker (
    input logic        clk,
    input logic        rst,
    input logic        mem_rd,
    input logic [15:0] mem_addr,
    input logic        done,
    input logic [1:0]  ins_len,
    input logic [15:0] next_pc,
    input logic [15:0] ret_addr
);
    logic [2:0] run;

    always_ff @(posedge clk) begin
        if (rst)         run <= '0;
        else if (mem_rd) run <= run + 3'd1;
        else             run <= '0;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !mem_rd));

    a_r3_max_three_reads: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (run < 3'd3));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    a_r2_len_matches_reads: assert property (@(posedge clk) disable iff (rst)
        done |-> ({1'b0, ins_len} == run));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_after_read: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_rd));

    a_r6_next_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> (next_pc == $past(mem_addr) + 16'd1));

    a_r7_ret_is_next: assert property (@(posedge clk) disable iff (rst)
        done |-> (ret_addr == next_pc));

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !mem_rd);
endmodule

bind varlen_fetch vf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .done     (done),
    .ins_len  (ins_len),
    .next_pc  (next_pc),
    .ret_addr (ret_addr)
);

// File: tb/sim_varlen_fetch.sv
`timescale 1ns/1ps
module sim_varlen_fetch;
    localparam logic [15:0] BASE = 16'h1230;

    typedef struct {
        logic [7:0]  opc;
        logic [15:0] opnd;
        logic [1:0]  len;
        logic [15:0] first;
        logic [15:0] nxt;
        logic [15:0] rel;
        int          done_cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  opcode;
    logic [15:0] operand;
    logic [1:0]  ins_len;
    logic        done;
    logic [15:0] next_pc;
    logic [15:0] ret_addr;
    logic [15:0] rel_target;

    logic [7:0]  mem [256];
    exp_t        sb [$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          rd_cnt = 0;
    logic [15:0] rd_first = '0;
    logic        prev_done = 1'b0;
    logic [15:0] pc_model = BASE;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always_comb mem_rdata = mem[mem_addr[7:0]];

    varlen_fetch #(.RESET_ADDR(BASE)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .opcode(opcode),
        .operand(operand), .ins_len(ins_len), .done(done),
        .next_pc(next_pc), .ret_addr(ret_addr), .rel_target(rel_target)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: track reads and compare each completed instruction.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) chk(!done, "R5", "done width", 32'(done), 0);
            if (mem_rd) begin
                if (rd_cnt == 0) rd_first = mem_addr;
                else chk(mem_addr == rd_first + 16'(rd_cnt), "R3", "read addr",
                         32'(mem_addr), 32'(rd_first + 16'(rd_cnt)));
                rd_cnt++;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.done_cyc, "R5", "done cycle", 32'(cyc), 32'(e.done_cyc));
                    chk(opcode == e.opc, "R4", "opcode", 32'(opcode), 32'(e.opc));
                    chk(operand == e.opnd, "R4", "operand", 32'(operand), 32'(e.opnd));
                    chk(ins_len == e.len, "R2", "length", 32'(ins_len), 32'(e.len));
                    chk(rd_cnt == int'(e.len), "R3", "read count", 32'(rd_cnt), 32'(e.len));
                    chk(rd_first == e.first, "R3", "first addr", 32'(rd_first), 32'(e.first));
                    chk(next_pc == e.nxt, "R6", "next pc", 32'(next_pc), 32'(e.nxt));
                    chk(ret_addr == e.nxt, "R7", "return addr", 32'(ret_addr), 32'(e.nxt));
                    chk(rel_target == e.rel, "R8", "rel target", 32'(rel_target), 32'(e.rel));
                end
                rd_cnt = 0;
            end
            prev_done = done;
        end
    end

    // Driver: place bytes at the model PC, push the expectation, strobe start.
    task automatic fetch(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input int poke);
        exp_t e;
        logic [1:0] l;
        case (b0[7:6])
            2'b01:   l = 2'd2;
            2'b10:   l = 2'd3;
            default: l = 2'd1;
        endcase
        mem[pc_model[7:0]]         = b0;
        mem[8'(pc_model[7:0] + 1)] = b1;
        mem[8'(pc_model[7:0] + 2)] = b2;
        e.opc   = b0;
        e.len   = l;
        e.opnd  = (l == 2'd1) ? 16'h0 : (l == 2'd2) ? {8'h00, b1} : {b2, b1};
        e.first = pc_model;
        e.nxt   = pc_model + 16'(l);
        e.rel   = pc_model + {{8{e.opnd[7]}}, e.opnd[7:0]};
        @(negedge clk);
        e.done_cyc = cyc + 1 + int'(l);
        sb.push_back(e);
        start_i = 1'b1;
        for (int i = 0; i < poke; i++) @(negedge clk);   // R9: hold start while busy
        @(negedge clk);
        start_i = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!mem_rd, "R9", "idle after done", 32'(mem_rd), 0);
        end
        pc_model = e.nxt;
    endtask

    task automatic run_all();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!done && !mem_rd, "R1", "in reset", 32'({done, mem_rd}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !mem_rd, "R1", "after reset", 32'({done, mem_rd}), 0);
        chk(next_pc == BASE, "R1", "reset pc", 32'(next_pc), 32'(BASE));
        fetch(8'h05, 8'h00, 8'h00, 2);  // R2 class 00, start held through done
        fetch(8'h47, 8'hFE, 8'h00, 0);  // R8 negative displacement
        fetch(8'h00, 8'h00, 8'h00, 0);  // 1-byte, puts next at 0x1234
        fetch(8'h8C, 8'hCD, 8'hAB, 2);  // R7 3-byte at 0x1234 -> 0x1237
        fetch(8'h41, 8'h80, 8'h00, 0);  // R8 most negative displacement
        fetch(8'hC3, 8'h00, 8'h00, 0);  // R2 class 11 -> 1 byte
        fetch(8'h7F, 8'h7F, 8'h00, 0);  // R8 largest positive displacement
        fetch(8'hBE, 8'h00, 8'hFF, 0);  // R4 high byte only
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "R5", "watchdog", 0, 1);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule